// File: doc/BRIEF.md
# Dual-Channel Serial Code Loader

This block takes command frames from a three-wire serial link (serial clock, serial data, active-low frame sync) and keeps two 12-bit two's complement output codes, one per channel. Each frame carries a channel select bit, a shutdown flag and a 12-bit code. The block samples the three wires into a faster system clock domain, shifts in one bit on each detected rising serial clock edge while the frame is active, and commits the frame when frame sync returns high.

The committed frame updates only the addressed channel. The shutdown flag goes to a shared output register on every commit. Each channel also presents an offset-binary copy of its code for a converter core that counts up from the most negative value. A one-cycle strobe marks each channel update. After reset both channels hold the two's complement zero code, which is midscale on the offset-binary outputs.

The system clock must run at least four times faster than the serial clock, and each serial level must be held for at least two system clock periods.

Top module: `dual_code_loader`

## Requirements
- R1: After reset, code_a and code_b are 0x000, obin_a and obin_b are 0x800, shdn is 0 and both strobes are low.
- R2: While ser_frm_n is low, each rising edge of ser_clk shifts ser_dat into a 16-bit register, most significant bit first. Falling edges shift nothing.
- R3: Rising edges of ser_clk while ser_frm_n is high leave the shift register unchanged.
- R4: On each rising edge of ser_frm_n the low 12 bits of the register load one channel. Frame bit 15 selects the channel: 0 is channel A, 1 is channel B. The other channel keeps its code.
- R5: Frame bit 13 is latched into shdn at every frame end, whichever channel is addressed. shdn stays set until a later frame clears it.
- R6: Frame bits 14 and 12 have no effect on either code or on shdn.
- R7: obin_a and obin_b equal their channel code plus 0x800, modulo 4096. That is the code with its top bit inverted.
- R8: If more than 16 bits arrive in one frame, only the last 16 are kept.
- R9: If fewer than 16 bits arrive in a frame, the load still happens. It uses the register contents, with earlier bits shifted up.
- R10: Each load raises exactly one strobe, upd_a or upd_b, for exactly one cycle, in the cycle the new code appears. A code changes only together with its own strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock, asynchronous to clk |
| ser_dat | input | 1 | Serial data, sampled on rising ser_clk |
| ser_frm_n | input | 1 | Frame sync, active low; rising edge commits |
| code_a | output | 12 | Channel A two's complement code |
| code_b | output | 12 | Channel B two's complement code |
| obin_a | output | 12 | Channel A offset-binary code |
| obin_b | output | 12 | Channel B offset-binary code |
| upd_a | output | 1 | One-cycle strobe on channel A load |
| upd_b | output | 1 | One-cycle strobe on channel B load |
| shdn | output | 1 | Shutdown flag from the last frame |

## Verification
Full frames alternate between the two channels, so any frame that leaks into the wrong channel shows up. They carry positive full scale, negative full scale and minus one LSB; these codes separate a correct offset-binary view from a plain copy or an off-by-one. One frame sets the shutdown flag and the two ignored bits, and the next frame, sent to the other channel, clears shutdown. This shows that shutdown is taken from every frame and that the ignored bits stay out of the code. Serial clocks sent while the frame is inactive, followed by a short frame, show whether those clocks shift. A frame that is too long shows whether only the last 16 bits are kept.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
  parameter int FRAME_W = 16;
  parameter int CODE_W  = 12;

  // Two's complement to offset binary: flip the sign bit.
  function automatic logic [CODE_W-1:0] offset_view(input logic [CODE_W-1:0] c);
    return {~c[CODE_W-1], c[CODE_W-2:0]};
  endfunction

  // Two's complement zero code, loaded at reset.
  function automatic logic [CODE_W-1:0] zero_code();
    return '0;
  endfunction
endpackage

// File: rtl/dcl_sync.sv
module dcl_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] st [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[s] <= RST_VAL;
        else        st[s] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[s] <= RST_VAL;
        else        st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/dcl_edge.sv
module dcl_edge #(
  parameter int               WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl;

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/dcl_shift.sv
module dcl_shift #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               bit_in,
  output logic [FRAME_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        q <= '0;
    else if (shift_en) q <= {q[FRAME_W-2:0], bit_in};
endmodule

// File: rtl/dcl_chan.sv
module dcl_chan
  import dcl_pkg::*;
#(
  parameter int CODE_W = dcl_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] din,
  output logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] obin,
  output logic              upd
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      code <= zero_code();
      upd  <= 1'b0;
    end else begin
      upd <= load;
      if (load) code <= din;
    end

  assign obin = offset_view(code);
endmodule

// File: rtl/dual_code_loader.sv
module dual_code_loader
  import dcl_pkg::*;
#(
  parameter int FRAME_W     = dcl_pkg::FRAME_W,
  parameter int CODE_W      = dcl_pkg::CODE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_frm_n,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic [CODE_W-1:0] obin_a,
  output logic [CODE_W-1:0] obin_b,
  output logic              upd_a,
  output logic              upd_b,
  output logic              shdn
);
  localparam int ADDR_BIT = FRAME_W - 1;
  localparam int SD_BIT   = FRAME_W - 3;
  localparam int N_CH     = 2;
  // Bit order of the synchronized vector: {frame, data, clock}; frame idles high.
  localparam logic [2:0] SYNC_IDLE = 3'b100;

  logic [2:0]         sync_lvl;
  logic [1:0]         edge_rise;
  logic               clk_rise;
  logic               frm_rise;
  logic               sh_fire;
  logic [FRAME_W-1:0] sh_q;
  logic [CODE_W-1:0]  code_v [N_CH];
  logic [CODE_W-1:0]  obin_v [N_CH];
  logic [N_CH-1:0]    upd_v;

  dcl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_frm_n, ser_dat, ser_clk}),
    .q(sync_lvl)
  );

  dcl_edge #(.WIDTH(2), .RST_VAL(2'b10)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .lvl({sync_lvl[2], sync_lvl[0]}),
    .rise(edge_rise)
  );

  assign clk_rise = edge_rise[0];
  assign frm_rise = edge_rise[1];
  assign sh_fire  = clk_rise & ~sync_lvl[2];

  dcl_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .shift_en(sh_fire), .bit_in(sync_lvl[1]),
    .q(sh_q)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    dcl_chan #(.CODE_W(CODE_W)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .load(frm_rise && (sh_q[ADDR_BIT] == 1'(ch))),
      .din(sh_q[CODE_W-1:0]),
      .code(code_v[ch]), .obin(obin_v[ch]), .upd(upd_v[ch])
    );
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        shdn <= 1'b0;
    else if (frm_rise) shdn <= sh_q[SD_BIT];

  assign code_a = code_v[0];
  assign code_b = code_v[1];
  assign obin_a = obin_v[0];
  assign obin_b = obin_v[1];
  assign upd_a  = upd_v[0];
  assign upd_b  = upd_v[1];
endmodule

// File: rtl/dual_code_loader_chk.sv
module dual_code_loader_chk #(
  parameter int FRAME_W = 16,
  parameter int CODE_W  = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CODE_W-1:0]  code_a,
  input logic [CODE_W-1:0]  code_b,
  input logic               upd_a,
  input logic               upd_b,
  input logic               shdn,
  input logic               frm_rise,
  input logic               sh_fire,
  input logic [FRAME_W-1:0] sh_q
);
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({upd_a, upd_b}) <= 1);

  p_strobe_short_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_a |=> !upd_a);

  p_strobe_short_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_b |=> !upd_b);

  p_strobe_after_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_a || upd_b) |-> $past(frm_rise));

  p_code_a_moves_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_a) |-> upd_a);

  p_code_b_moves_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_b) |-> upd_b);

  p_shdn_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shdn) |-> $past(frm_rise));

  p_no_shift_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_fire |=> $stable(sh_q));
endmodule

bind dual_code_loader dual_code_loader_chk #(.FRAME_W(FRAME_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .code_a(code_a), .code_b(code_b),
  .upd_a(upd_a), .upd_b(upd_b), .shdn(shdn),
  .frm_rise(frm_rise), .sh_fire(sh_fire), .sh_q(sh_q)
);

// File: tb/dual_code_loader_bench.sv
module dual_code_loader_bench;
  typedef struct {
    logic [11:0] ea;
    logic [11:0] eb;
    logic        esd;
    logic        ech;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_dat = 1'b0;
  logic ser_frm_n = 1'b1;
  logic [11:0] code_a, code_b, obin_a, obin_b;
  logic upd_a, upd_b, shdn;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  exp_t q[$];

  // bench model state
  logic [15:0] m_sh = 16'h0;
  logic [11:0] m_a = 12'h0;
  logic [11:0] m_b = 12'h0;
  logic        m_sd = 1'b0;

  always #10 clk = ~clk;

  dual_code_loader u_dual_code_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_frm_n(ser_frm_n), .code_a(code_a), .code_b(code_b),
    .obin_a(obin_a), .obin_b(obin_b), .upd_a(upd_a), .upd_b(upd_b),
    .shdn(shdn)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sclk(input logic b);
    ser_dat = b;
    hold(4);
    ser_clk = 1'b1;
    hold(4);
    ser_clk = 1'b0;
  endtask

  // Sends n bits of v, MSB first, as one frame and queues the expected result.
  task automatic send_frame(input logic [31:0] v, input int n);
    exp_t e;
    ser_frm_n = 1'b0;
    hold(4);
    for (int i = n - 1; i >= 0; i--) begin
      pulse_sclk(v[i]);
      m_sh = {m_sh[14:0], v[i]};
    end
    hold(4);
    if (m_sh[15]) m_b = m_sh[11:0];
    else          m_a = m_sh[11:0];
    m_sd  = m_sh[13];
    e.ea  = m_a;
    e.eb  = m_b;
    e.esd = m_sd;
    e.ech = m_sh[15];
    q.push_back(e);
    ser_frm_n = 1'b1;
    hold(12);
  endtask

  // Monitor: pops the expected item on each strobe.
  logic pa = 1'b0, pb = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pa && upd_a) chk("R10", "upd_a width", 2, 1);
      if (pb && upd_b) chk("R10", "upd_b width", 2, 1);
      if (upd_a || upd_b) begin
        if (q.size() == 0) begin
          chk("R10", "unexpected strobe", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk("R10", "strobe channel", {upd_b, upd_a}, e.ech ? 2 : 1);
          chk("R4",  "code_a", code_a, e.ea);
          chk("R4",  "code_b", code_b, e.eb);
          chk("R7",  "obin_a", obin_a, (e.ea + 12'h800) % 4096);
          chk("R7",  "obin_b", obin_b, (e.eb + 12'h800) % 4096);
          chk("R5",  "shdn", shdn, e.esd);
        end
      end
    end
    pa <= upd_a;
    pb <= upd_b;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    hold(3);
    rst_n = 1'b1;
    hold(3);
    // R1 reset state
    chk("R1", "code_a", code_a, 0);
    chk("R1", "code_b", code_b, 0);
    chk("R1", "obin_a", obin_a, 12'h800);
    chk("R1", "obin_b", obin_b, 12'h800);
    chk("R1", "shdn", shdn, 0);
    chk("R1", "strobes", {upd_a, upd_b}, 0);

    // R2 R4: positive full scale to A, negative full scale to B
    send_frame(32'h07FF, 16);
    send_frame(32'h8800, 16);
    // R5 R6: A gets minus one LSB with shutdown and both ignored bits set
    send_frame(32'h7FFF, 16);
    // R5: B frame clears shutdown
    send_frame(32'h8001, 16);
    // R3: serial clocks with frame inactive must not shift
    for (int k = 0; k < 5; k++) pulse_sclk(1'b1);
    hold(8);
    // R9: short frame of 8 bits on top of the held contents
    send_frame(32'h00A5, 8);
    chk("R9", "short frame code_a", code_a, 12'h1A5);
    chk("R3", "code_b kept", code_b, 12'h001);
    // R8: 20-bit frame keeps the last 16
    send_frame(32'hF0123, 20);
    chk("R8", "long frame code_a", code_a, 12'h123);
    chk("R6", "shdn after long frame", shdn, 0);

    hold(20);
    chk("R10", "pending loads", q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule